// File: doc/BRIEF.md
# Packed Bit-Field Unpacker

This block turns a dense stream of unsigned integers into 32-bit words. The integers have one fixed width and are packed back to back with no padding. The width is a runtime setting from 1 to 31 bits. Input arrives as 128-bit segments on a valid/ready port. Output leaves as 128-bit beats holding four zero-extended 32-bit lanes, also on a valid/ready port.

Packing is LSB-first: field i occupies stream bits i*W upward, where W is the width. Segment k supplies stream bits 128*k to 128*k+127. Internally the block keeps a two-segment bit buffer, so a field whose bits span two segments is put back together before extraction.

Each lane is extracted in three steps:
- a byte-routing step copies the five bytes that hold the field into a per-lane window;
- a per-lane right shift by the field's offset within its first byte follows;
- a common mask of W ones clears the bits of neighbouring fields.

The producer marks the final segment of a stream with a last flag. The block then drains every whole field that remains, flags the final beat, and discards trailing bits that are too few to form a field.

Top module: `upk_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Lane k (bits 32k+31:32k) of output beat j carries field 4j+k, zero-extended. Field i is taken from stream bits i*W to i*W+W-1, with the lowest stream bit in lane bit 0.
- R3: Every width from 1 to 31 set on cfg_width unpacks correctly. cfg_width is held constant while a stream is in flight.
- R4: Fields that cross a 128-bit segment boundary are delivered whole. A stream of S segments yields exactly floor(128*S/W) fields.
- R5: Every beat except the final beat of a stream carries four fields, with out_lanes = 4'b1111 and out_last = 0.
- R6: The final beat has out_last = 1 and carries the 1 to 4 remaining fields in the lowest lanes. out_lanes is a thermometer mask of those lanes (bit k set means lane k is valid), and unused lanes read zero. Trailing bits fewer than W are dropped.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_lanes and out_last hold their values into the next cycle.
- R8: Once a segment with in_last = 1 is accepted, in_ready stays 0 until the final beat of that stream is taken.
- R9: The buffer holds two segments. With the output stalled and W = 31, exactly two segments are accepted and in_ready then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_width | input | 5 | Field width W, 1 to 31 |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Block can accept a segment |
| in_data | input | 128 | Packed segment, stream bit order LSB-first |
| in_last | input | 1 | Segment is the final one of the stream |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 128 | Four zero-extended 32-bit lanes |
| out_lanes | output | 4 | Thermometer mask of valid lanes |
| out_last | output | 1 | Beat is the final one of the stream |

## Verification
The bench targets widths where fields straddle segment boundaries at every offset: 17, 23, 30 and 31 bits, plus the degenerate 1-bit case. A design with a wrong carry or refill shift would corrupt exactly those fields. All-ones and alternating patterns expose a mask that is one bit too wide or too narrow, since such a mask leaks neighbour bits into a lane. Random stalls on both sides check that a held beat stays stable and that no segment slips in while the stream drains. A stalled output at W = 31 probes the two-segment capacity: an off-by-one in the room check would accept a third segment and overwrite live bits.

// File: rtl/upk_pkg.sv
package upk_pkg;
  localparam int unsigned SEG_W  = 128;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WID_W  = 5;
endpackage

// File: rtl/upk_lane_count.sv
module upk_lane_count #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WID_W  = 5,
  parameter int unsigned FILL_W = 9,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [FILL_W-1:0] fill,
  input  logic [WID_W-1:0]  width,
  output logic [LANES-1:0]  lane_en,
  output logic [CNT_W-1:0]  n_lanes
);
  for (genvar k = 0; k < LANES; k++) begin : g_fit
    assign lane_en[k] = (width != '0) &&
                        (fill >= FILL_W'(k + 1) * FILL_W'(width));
  end

  always_comb begin
    n_lanes = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_en[k]) n_lanes = CNT_W'(k + 1);
    end
  end
endmodule

// File: rtl/upk_lane_extract.sv
module upk_lane_extract #(
  parameter int unsigned BUF_W    = 256,
  parameter int unsigned LANE_W   = 32,
  parameter int unsigned WID_W    = 5,
  parameter int unsigned FILL_W   = 9,
  parameter int unsigned LANE_IDX = 0,
  localparam int unsigned WIN_W   = LANE_W + 8
) (
  input  logic [BUF_W-1:0]  buf_bits,
  input  logic [WID_W-1:0]  width,
  output logic [LANE_W-1:0] field
);
  logic [FILL_W-1:0] start_bit;
  logic [FILL_W-1:0] byte_sel;
  logic [BUF_W-1:0]  routed;
  logic [WIN_W-1:0]  window;
  logic [WIN_W-1:0]  aligned;
  logic [LANE_W-1:0] mask;

  always_comb begin
    start_bit = FILL_W'(LANE_IDX) * FILL_W'(width);
    byte_sel  = start_bit >> 3;
    // stage 1: byte routing into a five-byte window
    routed    = buf_bits >> {byte_sel, 3'b000};
    window    = routed[WIN_W-1:0];
    // stage 2: per-lane alignment shift
    aligned   = window >> start_bit[2:0];
    // stage 3: common width mask
    mask      = ~({LANE_W{1'b1}} << width);
    field     = aligned[LANE_W-1:0] & mask;
  end
endmodule

// File: rtl/upk_bitbuf.sv
module upk_bitbuf #(
  parameter int unsigned SEG_W  = 128,
  parameter int unsigned BUF_W  = 256,
  parameter int unsigned FILL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEG_W-1:0]  push_data,
  input  logic              push_last,
  input  logic              pop,
  input  logic [FILL_W-1:0] pop_bits,
  input  logic              clear,
  output logic [BUF_W-1:0]  buf_q,
  output logic [FILL_W-1:0] fill_q,
  output logic              pend_q
);
  logic [BUF_W-1:0]  buf_d;
  logic [FILL_W-1:0] fill_d;
  logic              pend_d;
  logic              upd_en;

  always_comb begin
    buf_d  = buf_q;
    fill_d = fill_q;
    pend_d = pend_q;
    if (clear) begin
      buf_d  = '0;
      fill_d = '0;
      pend_d = 1'b0;
    end else begin
      if (pop) begin
        buf_d  = buf_q >> pop_bits;
        fill_d = fill_q - pop_bits;
      end
      if (push) begin
        buf_d  = buf_d | (BUF_W'(push_data) << fill_d);
        fill_d = fill_d + FILL_W'(SEG_W);
        pend_d = pend_q | push_last;
      end
    end
    upd_en = clear | push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      buf_q  <= buf_d;
      fill_q <= fill_d;
      pend_q <= pend_d;
    end
  end

  // R9: stored bits never exceed the two-segment capacity
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(BUF_W));
  // R9: a push only lands when a whole segment of room remains
  a_r9_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill_q <= FILL_W'(SEG_W)));
  // R8: no push is taken once the final segment is held
  a_r8_no_push_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !push);
endmodule

// File: rtl/upk_unpacker.sv
module upk_unpacker
  import upk_pkg::*;
#(
  parameter int unsigned P_SEG_W  = SEG_W,
  parameter int unsigned P_LANE_W = LANE_W,
  parameter int unsigned P_LANES  = LANES,
  parameter int unsigned P_WID_W  = WID_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P_WID_W-1:0]    cfg_width,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [P_SEG_W-1:0]    in_data,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [P_SEG_W-1:0]    out_data,
  output logic [P_LANES-1:0]    out_lanes,
  output logic                  out_last
);
  localparam int unsigned BUF_W  = 2 * P_SEG_W;
  localparam int unsigned FILL_W = $clog2(BUF_W + 1);
  localparam int unsigned CNT_W  = $clog2(P_LANES + 1);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [BUF_W-1:0]          buf_q;
  logic [FILL_W-1:0]         fill_q;
  logic                      pend_q;
  logic [P_LANES-1:0]        lane_en;
  logic [CNT_W-1:0]          n_lanes;
  logic [FILL_W-1:0]         consumed;
  logic [FILL_W-1:0]         rem_bits;
  logic                      fire_in;
  logic                      fire_out;
  logic                      clear;
  logic [P_LANE_W-1:0]       lane_field [P_LANES];

  upk_bitbuf #(.SEG_W(P_SEG_W), .BUF_W(BUF_W), .FILL_W(FILL_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (fire_in),
    .push_data (in_data),
    .push_last (in_last),
    .pop       (fire_out),
    .pop_bits  (consumed),
    .clear     (clear),
    .buf_q     (buf_q),
    .fill_q    (fill_q),
    .pend_q    (pend_q)
  );

  upk_lane_count #(.LANES(P_LANES), .WID_W(P_WID_W), .FILL_W(FILL_W)) u_cnt (
    .fill    (fill_q),
    .width   (cfg_width),
    .lane_en (lane_en),
    .n_lanes (n_lanes)
  );

  for (genvar k = 0; k < P_LANES; k++) begin : g_lane
    upk_lane_extract #(
      .BUF_W(BUF_W), .LANE_W(P_LANE_W), .WID_W(P_WID_W),
      .FILL_W(FILL_W), .LANE_IDX(k)
    ) u_ext (
      .buf_bits (buf_q),
      .width    (cfg_width),
      .field    (lane_field[k])
    );
    assign out_data[k*P_LANE_W +: P_LANE_W] =
      (out_valid && lane_en[k]) ? lane_field[k] : '0;
  end

  always_comb begin
    out_valid = lane_en[P_LANES-1] || (pend_q && lane_en[0]);
    consumed  = FILL_W'(n_lanes) * FILL_W'(cfg_width);
    rem_bits  = fill_q - consumed;
    out_last  = out_valid && pend_q && (rem_bits < FILL_W'(cfg_width));
    out_lanes = out_valid ? lane_en : '0;
    in_ready  = rst_core_n && !pend_q && (fill_q <= FILL_W'(P_SEG_W));
    fire_in   = in_valid && in_ready;
    fire_out  = out_valid && out_ready;
    clear     = (fire_out && out_last) ||
                (pend_q && (cfg_width != '0) && !lane_en[0]);
  end

  // R7: a stalled beat is held unchanged
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_lanes) && $stable(out_last)));
  // R5: any beat that is not the final one is full
  a_r5_full_beat: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_last) |-> (out_lanes == {P_LANES{1'b1}}));
  // R6: the final beat carries at least one field
  a_r6_last_nonempty: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && out_last) |-> out_lanes[0]);
  // R8: after the final beat is taken the input reopens
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && out_ready && out_last) |=> in_ready);
endmodule

// File: tb/upk_unpacker_tb.sv
module upk_unpacker_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [4:0]   cfg_width;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic         in_last;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic [3:0]   out_lanes;
  logic         out_last;

  always #10 clk = ~clk;

  upk_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lanes(out_lanes), .out_last(out_last)
  );

  int errors = 0;
  int checks = 0;
  logic [127:0] segs[$];
  logic [127:0] exp_d[$];
  logic [3:0]   exp_l[$];
  bit           exp_last[$];
  int  delivered = 0;
  int  acc_cnt = 0;
  bit  draining = 0;
  bit  hold_out = 0;
  bit  mon_en = 0;
  bit  stalled_prev = 0;
  logic [127:0] s_d;
  logic [3:0]   s_l;
  logic         s_last;

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary_and_end();
  end

  // output ready driver
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      out_ready = !hold_out && mon_en && (($urandom % 10) < 7);
    end
  end

  // output monitor and reference comparison
  always @(negedge clk) begin
    if (mon_en) begin
      if (stalled_prev) begin
        checks++;
        if (!out_valid || out_data !== s_d || out_lanes !== s_l || out_last !== s_last) begin
          errors++;
          $display("FAIL R7 stall hold: actual v=%0b d=%h l=%b expected d=%h l=%b",
                   out_valid, out_data, out_lanes, s_d, s_l);
        end
      end
      stalled_prev = out_valid && !out_ready;
      s_d = out_data; s_l = out_lanes; s_last = out_last;

      if (draining) begin
        checks++;
        if (in_ready !== 1'b0) begin
          errors++;
          $display("FAIL R8 input open while draining: actual=%0b expected=0", in_ready);
        end
      end

      if (out_valid && out_ready) begin
        checks++;
        if (exp_d.size() == 0) begin
          errors++;
          $display("FAIL R4 unexpected beat: actual=%h expected=none", out_data);
        end else begin
          if (out_data !== exp_d[0]) begin
            errors++;
            $display("FAIL R2 lane data: actual=%h expected=%h", out_data, exp_d[0]);
          end else if (out_lanes !== exp_l[0]) begin
            errors++;
            $display("FAIL %s lane mask: actual=%b expected=%b",
                     exp_last[0] ? "R6" : "R5", out_lanes, exp_l[0]);
          end else if (out_last !== exp_last[0]) begin
            errors++;
            $display("FAIL R6 last flag: actual=%0b expected=%0b", out_last, exp_last[0]);
          end
          delivered += $countones(out_lanes);
          if (out_last) draining = 0;
          void'(exp_d.pop_front()); void'(exp_l.pop_front()); void'(exp_last.pop_front());
        end
      end
    end
  end

  function automatic bit stream_bit(int pos);
    return segs[pos / 128][pos % 128];
  endfunction

  task automatic build(input int w, input int nseg, input int pat);
    int total;
    int nf;
    int nb;
    segs.delete();
    for (int s = 0; s < nseg; s++) begin
      logic [127:0] v;
      case (pat)
        1:       v = '1;
        2:       v = {32{4'hA}};
        default: v = {$urandom, $urandom, $urandom, $urandom};
      endcase
      segs.push_back(v);
    end
    total = nseg * 128;
    nf = total / w;
    nb = (nf + 3) / 4;
    for (int b = 0; b < nb; b++) begin
      logic [127:0] d;
      int n;
      d = '0;
      n = (nf - 4 * b) < 4 ? (nf - 4 * b) : 4;
      for (int k = 0; k < n; k++)
        for (int j = 0; j < w; j++)
          d[32 * k + j] = stream_bit((4 * b + k) * w + j);
      exp_d.push_back(d);
      exp_l.push_back(4'((1 << n) - 1));
      exp_last.push_back(b == nb - 1);
    end
  endtask

  task automatic drive_input(input int nseg, input bit always_valid);
    int idx = 0;
    bit last_fired = 0;
    acc_cnt = 0;
    while (idx < nseg) begin
      @(posedge clk); #1;
      in_valid = always_valid || (($urandom % 10) < 7);
      in_data  = segs[idx];
      in_last  = (idx == nseg - 1);
      @(negedge clk);
      if (in_valid && in_ready) begin
        if (in_last) last_fired = 1;
        idx++;
        acc_cnt = idx;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
    if (last_fired) draining = 1;
  endtask

  task automatic run_test(input int w, input int nseg, input int pat, input bit cap_test);
    int nf;
    @(posedge clk); #1;
    cfg_width = 5'(w);   // R3: width under test
    build(w, nseg, pat);
    nf = (nseg * 128) / w;
    delivered = 0;
    if (cap_test) begin
      hold_out = 1;
      fork
        drive_input(nseg, 1'b1);
        begin
          repeat (10) @(posedge clk);
          #5;
          checks++;
          if (acc_cnt != 2) begin
            errors++;
            $display("FAIL R9 capacity: actual=%0d expected=2 segments", acc_cnt);
          end
          hold_out = 0;
        end
      join
    end else begin
      drive_input(nseg, 1'b0);
    end
    while (exp_d.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (delivered != nf) begin
      errors++;
      $display("FAIL R4 R3 field count w=%0d: actual=%0d expected=%0d", w, delivered, nf);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 0; in_last = 0; in_data = '0; cfg_width = 5'd17;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: actual v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end
    mon_en = 1;
    run_test(17, 3, 0, 0);
    run_test(1, 2, 0, 0);
    run_test(31, 4, 1, 0);
    run_test(8, 2, 2, 0);
    run_test(5, 3, 0, 0);
    run_test(31, 3, 0, 1);
    run_test(23, 1, 0, 0);
    run_test(30, 5, 1, 0);
    run_test(13, 4, 2, 0);
    summary_and_end();
  end
endmodule